// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer with PWM Output

This block is a 16-bit up-counter built for general timing work. It can run as a periodic timer, as a capture unit that records the count on an input edge, or as a PWM generator. Each count step comes from one of three places. The first is a system-clock prescaler with seven division taps. The second is an external pin, synchronised and edge-detected. The third is a one-cycle match pulse from a neighbouring timer, which lets timers be chained.

Two compare values are used. Value A sets the period: when the counter reaches A it returns to zero. Value B sets the PWM duty. Software writes both values into shadow copies, and the live copies only take them up when the period wraps. Changing the duty therefore never cuts a PWM cycle short.

A byte-wide register port gives software access to the compare values, the control fields, the captured value and the count. A count read cannot tear. An event flag drives the interrupt line. Either an acknowledge pulse or a software write clears the flag.

Top module: `pwm_timer16`

## Requirements
- R1: After reset, the control bytes (addresses 4 and 5), the count (address 6), `tmr_out` and `irq` all read 0.
- R2: Control byte 1 bits [2:0] select the prescaler tap. The codes 0, 1, 2, 3, 4, 5 and 6 divide the system clock by 1, 2, 4, 8, 64, 512 and 2048. Code 7 also divides by 2048.
- R3: Control byte 1 bit 3 selects the external source. When bit 3 = 1 and bit 4 = 0, the counter steps once per edge on `ext_pin`. Bit 5 chooses the edge: 0 counts rising edges, 1 counts falling edges.
- R4: When control byte 1 bit 3 = 1 and bit 4 = 1, each one-cycle pulse on `nb_match` advances the counter by exactly one.
- R5: A step taken while the count equals the live A value returns the counter to 0, so the period is A+1 steps. Control byte 0 bit 0 is the enable; while it is 0 the counter stays at 0. Writing 1 to control byte 0 bit 1 zeroes the counter once.
- R6: Writes to addresses 0/1 (A, low/high byte) and 2/3 (B, low/high byte) go into shadow copies. The live copies, which reads of the same addresses return, load the shadow values only on an A-match step or while the block is disabled.
- R7: Control byte 0 bits [3:2] select the mode: 00 is timer, 01 is capture, 10 is PWM and 11 behaves as timer. In timer mode `tmr_out` starts at the idle level given by control byte 0 bit 4 and toggles on every A-match step.
- R8: In PWM mode `tmr_out` is at the active level (the inverse of bit 4) while the count is below B, and at the idle level otherwise. As a result, B = 0 gives a constant idle output and B > A gives a constant active output.
- R9: In capture mode, control byte 1 bits [7:6] choose the capture edge on `cap_in`: 01 is rising, 10 is falling, 11 is both and 00 is off. On the chosen edge the count is latched (readable at addresses 8 and 9) and the flag is set. An edge that is not chosen has no effect.
- R10: The flag (`irq`, read at control byte 0 bit 7) is set by an A-match step in timer and PWM modes and by a capture in capture mode. It is cleared by `int_ack`, or by writing control byte 0 with bit 7 = 1.
- R11: An event in the same cycle as a clear leaves the flag set.
- R12: Reading address 6 returns the low byte of the count and saves the high byte at the same moment. Reading address 7 returns that saved high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (triggers the count snapshot) |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational on rd_addr |
| ext_pin | input | 1 | External count input, asynchronous |
| nb_match | input | 1 | Neighbour timer match pulse, synchronous |
| cap_in | input | 1 | Capture trigger input, asynchronous |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| tmr_out | output | 1 | Timer / PWM output |
| irq | output | 1 | Event flag |

## Verification
Read data is combinational on the address, so it is checked two nanoseconds after the negative edge at which the address was driven. The same holds for the output and flag levels. A snapshot or a write only becomes visible one edge later.

The stimulus accounts for two fixed latencies:
- A neighbour pulse or an acknowledge acts at the next rising edge, so the bench samples the following negative edge.
- An `ext_pin` or `cap_in` change passes two synchroniser stages and an edge register, so it acts about three cycles later. The bench holds each pin level for four cycles and waits six before reading.

The prescaler taps and the PWM duty are checked as counts taken over a whole number of periods. The result is then fixed whatever the starting phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      MODE_TIMER = 2'b00,
      MODE_CAPT  = 2'b01,
      MODE_PWM   = 2'b10,
      MODE_RSVD  = 2'b11
   } tmr_mode_e;

   localparam logic [3:0] ADR_A_LO  = 4'd0;
   localparam logic [3:0] ADR_A_HI  = 4'd1;
   localparam logic [3:0] ADR_B_LO  = 4'd2;
   localparam logic [3:0] ADR_B_HI  = 4'd3;
   localparam logic [3:0] ADR_CTL0  = 4'd4;
   localparam logic [3:0] ADR_CTL1  = 4'd5;
   localparam logic [3:0] ADR_CNT_L = 4'd6;
   localparam logic [3:0] ADR_CNT_H = 4'd7;
   localparam logic [3:0] ADR_CAP_L = 4'd8;
   localparam logic [3:0] ADR_CAP_H = 4'd9;

   // log2 of the division ratio for each clock-select code
   function automatic int unsigned tap_shift(input logic [2:0] sel);
      case (sel)
         3'd0: return 0;
         3'd1: return 1;
         3'd2: return 2;
         3'd3: return 3;
         3'd4: return 6;
         3'd5: return 9;
         default: return 11;
      endcase
   endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   generate
      if (SYNC_N < 2) begin : g_bad
         $error("tmr_edge_sync: SYNC_N must be at least 2");
      end
   endgenerate

   logic [SYNC_N:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_N-1:0], din};
   end

   assign rise = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
   assign fall = ~sh_q[SYNC_N-1] & sh_q[SYNC_N];

   // R3
   rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise);
   // R3
   fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !fall);
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
   import tmr_pkg::*;
#(
   parameter int PRE_W  = 11,
   parameter int SYNC_N = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [2:0] clk_sel,
   input  logic       ext_en,
   input  logic       ext_src,
   input  logic       ext_fall,
   input  logic       ext_pin,
   input  logic       nb_match,
   output logic       tick
);
   generate
      if (PRE_W < 11) begin : g_bad
         $error("tmr_tick_gen: PRE_W must cover the divide-by-2048 tap");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;
   logic             pre_tick;
   logic             pin_rise, pin_fall;
   logic             ext_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (!en) pre_q <= '0;
      else          pre_q <= pre_q + 1'b1;
   end

   assign mask     = PRE_W'((32'd1 << tap_shift(clk_sel)) - 32'd1);
   assign pre_tick = ((pre_q & mask) == mask);

   tmr_edge_sync #(.SYNC_N(SYNC_N)) i_pin_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_pin), .rise(pin_rise), .fall(pin_fall)
   );

   assign ext_tick = ext_src ? nb_match : (ext_fall ? pin_fall : pin_rise);
   assign tick     = en & (ext_en ? ext_tick : pre_tick);

   // R2
   pre_tap2048_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ext_en && clk_sel == 3'd7 && pre_tick) |=> !tick);
endmodule

// File: rtl/tmr_cmp_buf.sv
module tmr_cmp_buf #(
   parameter int W    = 16,
   parameter bit LESS = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [7:0]   wr_byte,
   input  logic         reload,
   input  logic [W-1:0] cnt,
   output logic [W-1:0] act,
   output logic         cmp
);
   logic [W-1:0] bfr_q, act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bfr_q <= '0;
      end else begin
         if (wr_lo) bfr_q[7:0]   <= wr_byte;
         if (wr_hi) bfr_q[W-1:8] <= wr_byte[W-9:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q <= '0;
      else if (reload) act_q <= bfr_q;
   end

   generate
      if (LESS) begin : g_lt
         assign cmp = (cnt < act_q);
      end else begin : g_eq
         assign cmp = (cnt == act_q);
      end
   endgenerate

   assign act = act_q;

   // R6
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> act_q == $past(act_q));
endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 11,
   parameter int SYNC_N = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   input  logic [3:0] rd_addr,
   output logic [7:0] rd_data,
   input  logic       ext_pin,
   input  logic       nb_match,
   input  logic       cap_in,
   input  logic       int_ack,
   output logic       tmr_out,
   output logic       irq
);
   localparam int N_CMP = 2;

   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad
         $error("pwm_timer16: CNT_W must lie in 9..16");
      end
   endgenerate

   logic             en_q, pol_q, ext_en_q, ext_src_q, ext_fall_q;
   tmr_mode_e        mode_q;
   logic [2:0]       clk_sel_q;
   logic [1:0]       cap_pol_q;
   logic [CNT_W-1:0] cnt_q, cap_q;
   logic [7:0]       snap_hi_q;
   logic             flag_q, tgl_q;

   logic             tick, reload, match_a_evt;
   logic             wr_ctl0, wr_ctl1, cnt_clr, sw_clr;
   logic             cap_rise, cap_fall, cap_evt, set_evt, clr_evt;
   logic [CNT_W-1:0] act [N_CMP];
   logic [N_CMP-1:0] cmp;
   logic [15:0]      cnt16, cap16, a16, b16;

   assign wr_ctl0 = wr_en && (wr_addr == ADR_CTL0);
   assign wr_ctl1 = wr_en && (wr_addr == ADR_CTL1);
   assign cnt_clr = wr_ctl0 && wr_data[1];
   assign sw_clr  = wr_ctl0 && wr_data[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; pol_q <= 1'b0; mode_q <= MODE_TIMER;
         clk_sel_q <= '0; ext_en_q <= 1'b0; ext_src_q <= 1'b0;
         ext_fall_q <= 1'b0; cap_pol_q <= '0;
      end else begin
         if (wr_ctl0) begin
            en_q   <= wr_data[0];
            mode_q <= tmr_mode_e'(wr_data[3:2]);
            pol_q  <= wr_data[4];
         end
         if (wr_ctl1) begin
            clk_sel_q  <= wr_data[2:0];
            ext_en_q   <= wr_data[3];
            ext_src_q  <= wr_data[4];
            ext_fall_q <= wr_data[5];
            cap_pol_q  <= wr_data[7:6];
         end
      end
   end

   tmr_tick_gen #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) i_tick (
      .clk(clk), .rst_n(rst_n), .en(en_q), .clk_sel(clk_sel_q),
      .ext_en(ext_en_q), .ext_src(ext_src_q), .ext_fall(ext_fall_q),
      .ext_pin(ext_pin), .nb_match(nb_match), .tick(tick)
   );

   assign match_a_evt = tick & cmp[0];
   assign reload      = match_a_evt | ~en_q;

   // index 0: period value A (equality), index 1: duty value B (less-than)
   for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
      tmr_cmp_buf #(.W(CNT_W), .LESS(g == 1)) i_cmp (
         .clk(clk), .rst_n(rst_n),
         .wr_lo(wr_en && wr_addr == 4'(2*g)),
         .wr_hi(wr_en && wr_addr == 4'(2*g+1)),
         .wr_byte(wr_data), .reload(reload), .cnt(cnt_q),
         .act(act[g]), .cmp(cmp[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!en_q || cnt_clr) cnt_q <= '0;
      else if (tick)             cnt_q <= cmp[0] ? '0 : cnt_q + 1'b1;
   end

   tmr_edge_sync #(.SYNC_N(SYNC_N)) i_cap_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_rise), .fall(cap_fall)
   );

   assign cap_evt = en_q && (mode_q == MODE_CAPT) &&
                    ((cap_pol_q[0] && cap_rise) || (cap_pol_q[1] && cap_fall));
   assign set_evt = (mode_q == MODE_CAPT) ? cap_evt : match_a_evt;
   assign clr_evt = int_ack | sw_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0; flag_q <= 1'b0; tgl_q <= 1'b0;
      end else begin
         if (cap_evt) cap_q <= cnt_q;
         flag_q <= set_evt | (flag_q & ~clr_evt);
         if (!en_q || mode_q == MODE_CAPT || mode_q == MODE_PWM) tgl_q <= 1'b0;
         else if (match_a_evt)                                   tgl_q <= ~tgl_q;
      end
   end

   always_comb begin
      case (mode_q)
         MODE_PWM:  tmr_out = pol_q ^ (en_q & cmp[1]);
         MODE_CAPT: tmr_out = pol_q;
         default:   tmr_out = pol_q ^ tgl_q;
      endcase
   end
   assign irq = flag_q;

   assign cnt16 = 16'(cnt_q);
   assign cap16 = 16'(cap_q);
   assign a16   = 16'(act[0]);
   assign b16   = 16'(act[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              snap_hi_q <= '0;
      else if (rd_en && rd_addr == ADR_CNT_L)  snap_hi_q <= cnt16[15:8];
   end

   always_comb begin
      case (rd_addr)
         ADR_A_LO:  rd_data = a16[7:0];
         ADR_A_HI:  rd_data = a16[15:8];
         ADR_B_LO:  rd_data = b16[7:0];
         ADR_B_HI:  rd_data = b16[15:8];
         ADR_CTL0:  rd_data = {flag_q, 2'b00, pol_q, mode_q, 1'b0, en_q};
         ADR_CTL1:  rd_data = {cap_pol_q, ext_fall_q, ext_src_q, ext_en_q, clk_sel_q};
         ADR_CNT_L: rd_data = cnt16[7:0];
         ADR_CNT_H: rd_data = snap_hi_q;
         ADR_CAP_L: rd_data = cap16[7:0];
         ADR_CAP_H: rd_data = cap16[15:8];
         default:   rd_data = 8'h00;
      endcase
   end

   // R5
   dis_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> cnt_q == '0);
   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag_q);
   // R10
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt && !set_evt) |=> !flag_q);
   // R8
   pwm_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PWM && act[1] == '0) |-> tmr_out == pol_q);
   // R12
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADR_CNT_L) |=> snap_hi_q == $past(cnt16[15:8]));
endmodule

// File: tb/test_pwm_timer16.sv
module test_pwm_timer16;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       ext_pin = 1'b0, nb_match = 1'b0, cap_in = 1'b0, int_ack = 1'b0;
   logic       tmr_out, irq;

   always #10 clk = ~clk;

   pwm_timer16 i_pwm_timer16 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ext_pin(ext_pin),
      .nb_match(nb_match), .cap_in(cap_in), .int_ack(int_ack),
      .tmr_out(tmr_out), .irq(irq)
   );

   // kind: 0 read data, 1 tmr_out, 2 irq, 3 measured value in act
   typedef struct {
      string tag;
      int    kind;
      int    exp;
      int    act;
   } item_t;

   item_t q[$];
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   initial begin : monitor
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            int    a;
            it = q.pop_front();
            case (it.kind)
               0: a = int'(rd_data);
               1: a = int'(tmr_out);
               2: a = int'(irq);
               default: a = it.act;
            endcase
            n_chk++;
            if (a != it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %0d expected %0d", it.tag, a, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic exp_rd(input logic [3:0] a, input int e, input string tag);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      q.push_back('{tag, 0, e, 0});
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic exp_pin(input int kind, input int e, input string tag);
      @(negedge clk);
      q.push_back('{tag, kind, e, 0});
   endtask

   task automatic exp_val(input int a, input int e, input string tag);
      @(negedge clk);
      q.push_back('{tag, 3, e, a});
   endtask

   task automatic pin_edges(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_pin = 1'b1;
         repeat (4) @(negedge clk);
         ext_pin = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic pin_set(input logic v);
      @(negedge clk); ext_pin = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic nb_pulse(input logic with_ack);
      @(negedge clk); nb_match = 1'b1; int_ack = with_ack;
      @(negedge clk); nb_match = 1'b0; int_ack = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk); int_ack = 1'b1;
      @(negedge clk); int_ack = 1'b0;
   endtask

   task automatic count_high(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #3;
         if (tmr_out) c++;
      end
   endtask

   task automatic count_toggles(input int n, output int c);
      logic prev;
      c = 0;
      @(negedge clk); #3; prev = tmr_out;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #3;
         if (tmr_out != prev) c++;
         prev = tmr_out;
      end
   endtask

   task automatic setup(input logic [15:0] a, input logic [15:0] b,
                        input logic [7:0] c1, input logic [7:0] c0);
      wr(4'd4, 8'h00);
      wr(4'd0, a[7:0]); wr(4'd1, a[15:8]);
      wr(4'd2, b[7:0]); wr(4'd3, b[15:8]);
      wr(4'd5, c1);
      wr(4'd4, c0);
   endtask

   initial begin : watchdog
      #(20 * 190000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : driver
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      exp_rd(4'd4, 0, "R1 ctl0");
      exp_rd(4'd5, 0, "R1 ctl1");
      exp_rd(4'd6, 0, "R1 count");
      exp_pin(1, 0, "R1 out");
      exp_pin(2, 0, "R1 irq");

      // R8 PWM duty, A=9 B=4: 4 of every 10 cycles active
      setup(16'd9, 16'd4, 8'h00, 8'h09);
      repeat (30) @(negedge clk);
      count_high(100, c); exp_val(c, 40, "R8 duty 4/10");
      setup(16'd9, 16'd0, 8'h00, 8'h09);
      repeat (30) @(negedge clk);
      count_high(100, c); exp_val(c, 0, "R8 B=0 idle");
      setup(16'd9, 16'd12, 8'h00, 8'h09);
      repeat (30) @(negedge clk);
      count_high(100, c); exp_val(c, 100, "R8 B>A active");
      setup(16'd9, 16'd4, 8'h00, 8'h19);
      repeat (30) @(negedge clk);
      count_high(100, c); exp_val(c, 60, "R8 inverted polarity");

      // R2 prescaler taps, timer mode A=0: toggle every division period
      setup(16'd0, 16'd0, 8'h02, 8'h01);
      repeat (20) @(negedge clk);
      count_toggles(64, c); exp_val(c, 16, "R2 div4");
      setup(16'd0, 16'd0, 8'h04, 8'h01);
      repeat (200) @(negedge clk);
      count_toggles(1024, c); exp_val(c, 16, "R2 div64");
      setup(16'd0, 16'd0, 8'h07, 8'h01);
      repeat (100) @(negedge clk);
      count_toggles(4096, c); exp_val(c, 2, "R2 code7 div2048");

      // R6 shadow values: write while running, live copy waits for A match
      setup(16'd1000, 16'd3, 8'h00, 8'h01);
      repeat (5) @(negedge clk);
      wr(4'd2, 8'h07); wr(4'd3, 8'h00);
      exp_rd(4'd2, 3, "R6 live B held");
      exp_rd(4'd1, 8'h03, "R6 live A high");
      repeat (1100) @(negedge clk);
      exp_rd(4'd2, 7, "R6 live B after match");

      // R3 rising edges on ext_pin, R12 tear-free count read
      setup(16'hFFFF, 16'd0, 8'h08, 8'h01);
      pin_edges(511);
      exp_rd(4'd6, 8'hFF, "R3 rising count low");
      pin_edges(1);
      exp_rd(4'd7, 8'h01, "R12 snapshot high");
      exp_rd(4'd6, 8'h00, "R12 new low");
      exp_rd(4'd7, 8'h02, "R12 new high");

      // R3 falling edges: 5 rises, 4 falls
      wr(4'd5, 8'h28);
      wr(4'd4, 8'h03);
      for (int i = 0; i < 4; i++) begin
         pin_set(1'b1); pin_set(1'b0);
      end
      pin_set(1'b1);
      repeat (6) @(negedge clk);
      exp_rd(4'd6, 4, "R3 falling count");
      pin_set(1'b0);

      // R5 counter-clear bit
      wr(4'd4, 8'h03);
      exp_rd(4'd6, 0, "R5 clear bit");

      // R4, R5, R7, R10 neighbour pulses, timer mode A=2
      setup(16'd2, 16'd0, 8'h18, 8'h01);
      ack();
      nb_pulse(1'b0);
      exp_rd(4'd6, 1, "R4 one pulse one step");
      nb_pulse(1'b0);
      exp_pin(2, 0, "R10 no flag before match");
      nb_pulse(1'b0);
      exp_pin(2, 1, "R10 flag on A match");
      exp_pin(1, 1, "R7 toggle on match");
      exp_rd(4'd6, 0, "R5 wrap to zero");
      ack();
      exp_pin(2, 0, "R10 ack clears");
      nb_pulse(1'b0); nb_pulse(1'b0); nb_pulse(1'b0);
      exp_pin(1, 0, "R7 second toggle");
      wr(4'd4, 8'h81);
      exp_pin(2, 0, "R10 software clear");
      exp_rd(4'd4, 8'h01, "R10 ctl0 readback");
      // R11 event coinciding with acknowledge
      nb_pulse(1'b0); nb_pulse(1'b0); nb_pulse(1'b1);
      exp_pin(2, 1, "R11 set wins over ack");

      // R9 capture mode
      setup(16'hFFFF, 16'd0, 8'h48, 8'h05);
      ack();
      pin_edges(10);
      @(negedge clk); cap_in = 1'b1;
      repeat (6) @(negedge clk);
      exp_rd(4'd8, 10, "R9 rising capture");
      exp_rd(4'd9, 0, "R9 capture high");
      exp_pin(2, 1, "R9 capture flag");
      ack();
      wr(4'd5, 8'h88);
      pin_edges(3);
      @(negedge clk); cap_in = 1'b0;
      repeat (6) @(negedge clk);
      exp_rd(4'd8, 13, "R9 falling capture");
      ack();
      pin_edges(2);
      @(negedge clk); cap_in = 1'b1;
      repeat (6) @(negedge clk);
      exp_rd(4'd8, 13, "R9 unselected edge ignored");
      exp_pin(2, 0, "R9 no flag on unselected edge");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule